// File: doc/BRIEF.md
# Indexed Configuration Port Controller

This block is the host-facing gateway to configuration space. It decodes two adjacent byte addresses: a key/index port at the programmed base and a data port at base+1. After reset the window is locked. While it is locked, index and data traffic is ignored, and the only action the block accepts is the enter key byte 55h written to the base address. Once the window is open, a byte written to the base address selects a register index and the data port reads or writes that register. Writing AAh to the base address closes the window again.

Indices 00h–2Fh always reach a small set of global registers, whichever device is selected. This set holds the logical device number (LDN) selector, identity bytes, a serial-IRQ enable and reserved locations. Indices 30h and above reach the bank of the device chosen by the LDN. The block keeps each device's activate bit at index 30h. All other bank indices go out on a side port with a claim/return handshake that completes in the same cycle. The base address is an input, so relocating the window is handled elsewhere.

Read data is registered. It appears together with a one-cycle valid pulse on the edge after the read strobe.

Top module: `cfg_port_ctrl`

## Requirements
- R1: While locked, writes to base+0 other than 55h and all writes to base+1 change no state, and reads of base+0 or base+1 return FFh.
- R2: Writing 55h to the base address while locked opens the window (cfg_mode=1). Any other byte leaves it locked.
- R3: While open, writing AAh to base+0 closes the window and leaves the index unchanged. Every other access keeps the window open.
- R4: While open, a write to base+0 sets the index, a read of base+0 returns it, and base+1 reads or writes the register that the index selects.
- R5: Index 07h is the read/write LDN selector. It picks the bank that indices 30h and above reach.
- R6: Indices 00h–2Fh reach the global registers regardless of LDN. Reserved indices (00h–06h, 08h–1Bh, 21h–23h, 25h–2Fh) read 00h and ignore writes.
- R7: The following indices are read-only, and writes to them are ignored: 1Ch (revision), 1Dh (sub-ID), 1Eh (device ID low byte), 1Fh (device ID high byte), 20h (fixed FEh).
- R8: Index 24h bit 2 is the serial-IRQ enable, which resets to 1 and drives serirq_en. The other bits of 24h read 0.
- R9: For each LDN below NUM_LDN, index 30h bit 0 is an activate bit that resets to 0 and drives dev_active[LDN]. Bits 7:1 of 30h read 0.
- R10: Bank indices other than 30h are forwarded on the dev_* port. An unclaimed read returns FFh. An LDN at or above NUM_LDN reads FFh at every bank index and forwards no write.
- R11: Reset closes the window and clears the index, the LDN and every activate bit.
- R12: A read strobe at base+0 or base+1 yields io_rvalid=1 with the data on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_base | input | ADDR_W | I/O address of the key/index port |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Registered read data |
| io_rvalid | output | 1 | Read data valid pulse |
| cfg_mode | output | 1 | Configuration window open |
| serirq_en | output | 1 | Serial IRQ enable |
| dev_active | output | NUM_LDN | Activate bit of each device |
| dev_ldn | output | 8 | Selected logical device number |
| dev_idx | output | 8 | Current register index |
| dev_wr | output | 1 | Bank register write strobe |
| dev_wdata | output | 8 | Bank register write data |
| dev_claim | input | 1 | Device owns dev_ldn/dev_idx this cycle |
| dev_rdata | input | 8 | Device read data when claimed |

## Verification
A wrong lock state shows on the next data-port read: the read returns FFh where a register value is expected, or a register value where FFh is expected. A corrupted index or LDN shows on the next read, because the read returns the wrong register's value. It also shows at once on dev_idx and dev_ldn. A lost or spurious activate or serirq write changes the matching output pin on the edge after the write, and a later readback confirms it.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] KEY_OPEN   = 8'h55;
  localparam logic [7:0] KEY_CLOSE  = 8'hAA;
  localparam logic [7:0] IX_LDN     = 8'h07;
  localparam logic [7:0] IX_REV     = 8'h1C;
  localparam logic [7:0] IX_SUBID   = 8'h1D;
  localparam logic [7:0] IX_ID_LO   = 8'h1E;
  localparam logic [7:0] IX_ID_HI   = 8'h1F;
  localparam logic [7:0] IX_LEGACY  = 8'h20;
  localparam logic [7:0] IX_MODE    = 8'h24;
  localparam logic [7:0] IX_GLB_TOP = 8'h2F;
  localparam logic [7:0] IX_ACT     = 8'h30;
  localparam logic [7:0] LEGACY_VAL = 8'hFE;
  localparam logic [7:0] EMPTY_RD   = 8'hFF;
  localparam int         SIRQ_BIT   = 2;

  typedef enum logic { WIN_LOCKED = 1'b0, WIN_OPEN = 1'b1 } win_state_e;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       base_wr,
  input  logic [7:0] wdata,
  output logic       open
);
  win_state_e st_q;

  always_ff @(posedge clk) begin
    if (rst) st_q <= WIN_LOCKED;
    else if (base_wr) begin
      case (st_q)
        WIN_LOCKED: if (wdata == KEY_OPEN)  st_q <= WIN_OPEN;
        WIN_OPEN:   if (wdata == KEY_CLOSE) st_q <= WIN_LOCKED;
        default:    st_q <= WIN_LOCKED;
      endcase
    end
  end

  assign open = (st_q == WIN_OPEN);

  a_r2_no_false_open: assert property (@(posedge clk) disable iff (rst)
    (!open && !(base_wr && wdata == KEY_OPEN)) |=> !open);
  a_r3_close_on_key: assert property (@(posedge clk) disable iff (rst)
    (open && base_wr && wdata == KEY_CLOSE) |=> !open);
  a_r3_stay_open: assert property (@(posedge clk) disable iff (rst)
    (open && !(base_wr && wdata == KEY_CLOSE)) |=> open);
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_port_pkg::*;
#(
  parameter logic [7:0]  REV_ID = 8'h01,
  parameter logic [7:0]  SUB_ID = 8'h10,
  parameter logic [15:0] DEV_ID = 16'h0002
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] idx,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] ldn,
  output logic       serirq_en
);
  logic [7:0] ldn_q;
  logic       sirq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ldn_q  <= 8'h00;
      sirq_q <= 1'b1;
    end else if (wr) begin
      if (idx == IX_LDN)  ldn_q  <= wdata;
      if (idx == IX_MODE) sirq_q <= wdata[SIRQ_BIT];
    end
  end

  always_comb begin
    rdata = 8'h00;
    case (idx)
      IX_LDN:    rdata = ldn_q;
      IX_REV:    rdata = REV_ID;
      IX_SUBID:  rdata = SUB_ID;
      IX_ID_LO:  rdata = DEV_ID[7:0];
      IX_ID_HI:  rdata = DEV_ID[15:8];
      IX_LEGACY: rdata = LEGACY_VAL;
      IX_MODE:   rdata[SIRQ_BIT] = sirq_q;
      default:   rdata = 8'h00;
    endcase
  end

  assign ldn       = ldn_q;
  assign serirq_en = sirq_q;

  a_r5_ldn_hold: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(ldn));
  a_r8_sirq_hold: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(serirq_en));
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_port_pkg::*;
#(
  parameter int NUM_LDN = 32,
  localparam int SEL_W  = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         ldn,
  input  logic [7:0]         idx,
  input  logic               wr,
  input  logic [7:0]         wdata,
  input  logic               ext_claim,
  input  logic [7:0]         ext_rdata,
  output logic [7:0]         rdata,
  output logic               ext_wr,
  output logic [NUM_LDN-1:0] active
);
  logic             ldn_ok;
  logic [SEL_W-1:0] sel;
  logic             act_wr;

  assign ldn_ok = ({1'b0, ldn} < 9'(NUM_LDN));
  assign sel    = ldn[SEL_W-1:0];
  assign act_wr = wr && ldn_ok && (idx == IX_ACT);
  assign ext_wr = wr && ldn_ok && (idx != IX_ACT);

  for (genvar g = 0; g < NUM_LDN; g++) begin : g_act
    always_ff @(posedge clk) begin
      if (rst) active[g] <= 1'b0;
      else if (act_wr && sel == SEL_W'(g)) active[g] <= wdata[0];
    end
  end

  always_comb begin
    if (!ldn_ok)              rdata = EMPTY_RD;
    else if (idx == IX_ACT)   rdata = {7'b0, active[sel]};
    else if (ext_claim)       rdata = ext_rdata;
    else                      rdata = EMPTY_RD;
  end

  a_r9_act_hold: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(active));
  a_r9_one_bit_per_write: assert property (@(posedge clk) disable iff (rst)
    wr |=> $countones(active ^ $past(active)) <= 1);
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          NUM_LDN = 32,
  parameter logic [7:0]  REV_ID  = 8'h01,
  parameter logic [7:0]  SUB_ID  = 8'h10,
  parameter logic [15:0] DEV_ID  = 16'h0002
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  port_base,
  input  logic [ADDR_W-1:0]  io_addr,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [7:0]         io_wdata,
  output logic [7:0]         io_rdata,
  output logic               io_rvalid,
  output logic               cfg_mode,
  output logic               serirq_en,
  output logic [NUM_LDN-1:0] dev_active,
  output logic [7:0]         dev_ldn,
  output logic [7:0]         dev_idx,
  output logic               dev_wr,
  output logic [7:0]         dev_wdata,
  input  logic               dev_claim,
  input  logic [7:0]         dev_rdata
);
  logic       hit_idx, hit_dat, base_wr, data_wr, glb_sel;
  logic [7:0] idx_q, glb_rdata, bank_rdata;

  assign hit_idx = (io_addr == port_base);
  assign hit_dat = (io_addr == port_base + ADDR_W'(1));
  assign base_wr = io_wr && hit_idx;
  assign data_wr = cfg_mode && io_wr && hit_dat;
  assign glb_sel = (idx_q <= IX_GLB_TOP);

  cfg_key_fsm u_key (
    .clk(clk), .rst(rst), .base_wr(base_wr), .wdata(io_wdata), .open(cfg_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) idx_q <= 8'h00;
    else if (cfg_mode && base_wr && io_wdata != KEY_CLOSE) idx_q <= io_wdata;
  end

  cfg_global_regs #(.REV_ID(REV_ID), .SUB_ID(SUB_ID), .DEV_ID(DEV_ID)) u_glb (
    .clk(clk), .rst(rst), .idx(idx_q), .wr(data_wr && glb_sel),
    .wdata(io_wdata), .rdata(glb_rdata), .ldn(dev_ldn), .serirq_en(serirq_en)
  );

  cfg_dev_bank #(.NUM_LDN(NUM_LDN)) u_bank (
    .clk(clk), .rst(rst), .ldn(dev_ldn), .idx(idx_q), .wr(data_wr && !glb_sel),
    .wdata(io_wdata), .ext_claim(dev_claim), .ext_rdata(dev_rdata),
    .rdata(bank_rdata), .ext_wr(dev_wr), .active(dev_active)
  );

  assign dev_idx   = idx_q;
  assign dev_wdata = io_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata  <= 8'h00;
      io_rvalid <= 1'b0;
    end else begin
      io_rvalid <= io_rd && (hit_idx || hit_dat);
      if (io_rd && (hit_idx || hit_dat)) begin
        if (!cfg_mode)    io_rdata <= EMPTY_RD;
        else if (hit_idx) io_rdata <= idx_q;
        else if (glb_sel) io_rdata <= glb_rdata;
        else              io_rdata <= bank_rdata;
      end
    end
  end

  a_r1_idx_locked: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |=> $stable(dev_idx));
  a_r1_locked_reads_ff: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mode && io_rd && (hit_idx || hit_dat)) |=> io_rdata == EMPTY_RD);
  a_r10_fwd_only_open: assert property (@(posedge clk) disable iff (rst)
    dev_wr |-> (cfg_mode && io_wr));
  a_r12_rvalid: assert property (@(posedge clk) disable iff (rst)
    (io_rd && (hit_idx || hit_dat)) |=> io_rvalid);
endmodule

// File: tb/sim_cfg_port_ctrl.sv
module sim_cfg_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_LDN = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] port_base = 16'h002E;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        io_rvalid, cfg_mode, serirq_en, dev_wr, dev_claim;
  logic [NUM_LDN-1:0] dev_active;
  logic [7:0]  dev_ldn, dev_idx, dev_wdata, dev_rdata, ext_reg;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_ctrl #(.NUM_LDN(NUM_LDN)) u0 (
    .clk(clk), .rst(rst), .port_base(port_base), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rvalid(io_rvalid), .cfg_mode(cfg_mode), .serirq_en(serirq_en),
    .dev_active(dev_active), .dev_ldn(dev_ldn), .dev_idx(dev_idx),
    .dev_wr(dev_wr), .dev_wdata(dev_wdata), .dev_claim(dev_claim),
    .dev_rdata(dev_rdata)
  );

  // external device model: LDN 05h owns index 60h
  assign dev_claim = (dev_ldn == 8'h05) && (dev_idx == 8'h60);
  assign dev_rdata = ext_reg;
  always @(posedge clk) begin
    if (rst) ext_reg <= 8'h00;
    else if (dev_wr && dev_ldn == 8'h05 && dev_idx == 8'h60) ext_reg <= dev_wdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input string req, input logic [7:0] exp);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0;
    check({req, " rvalid"}, {31'b0, io_rvalid}, 32'd1);
    check(req, {24'b0, io_rdata}, {24'b0, exp});
  endtask

  // {req[3:0], op(1=read), port(1=data), data, expected}
  localparam int NV = 62;
  localparam logic [21:0] VEC [NV] = '{
    {4'd1, 1'b1,1'b1,8'h00,8'hFF}, // R1 locked data read
    {4'd1, 1'b0,1'b0,8'h07,8'h00}, // R1 index write ignored
    {4'd2, 1'b0,1'b0,8'h55,8'h00}, // R2 open
    {4'd1, 1'b1,1'b0,8'h00,8'h00}, // R1 index still 00
    {4'd7, 1'b0,1'b0,8'h20,8'h00},
    {4'd7, 1'b1,1'b1,8'h00,8'hFE}, // R7 fixed FE
    {4'd7, 1'b0,1'b1,8'h11,8'h00},
    {4'd7, 1'b1,1'b1,8'h00,8'hFE}, // R7 read-only
    {4'd7, 1'b0,1'b0,8'h1E,8'h00},
    {4'd7, 1'b1,1'b1,8'h00,8'h02},
    {4'd7, 1'b0,1'b0,8'h1F,8'h00},
    {4'd7, 1'b1,1'b1,8'h00,8'h00},
    {4'd7, 1'b0,1'b0,8'h1D,8'h00},
    {4'd7, 1'b1,1'b1,8'h00,8'h10},
    {4'd7, 1'b0,1'b0,8'h1C,8'h00},
    {4'd7, 1'b1,1'b1,8'h00,8'h01},
    {4'd8, 1'b0,1'b0,8'h24,8'h00},
    {4'd8, 1'b1,1'b1,8'h00,8'h04}, // R8 default
    {4'd8, 1'b0,1'b1,8'h00,8'h00},
    {4'd8, 1'b1,1'b1,8'h00,8'h00},
    {4'd8, 1'b0,1'b1,8'hFF,8'h00},
    {4'd8, 1'b1,1'b1,8'h00,8'h04}, // R8 other bits 0
    {4'd6, 1'b0,1'b0,8'h03,8'h00},
    {4'd6, 1'b0,1'b1,8'h5A,8'h00},
    {4'd6, 1'b1,1'b1,8'h00,8'h00}, // R6 reserved
    {4'd5, 1'b0,1'b0,8'h07,8'h00},
    {4'd5, 1'b0,1'b1,8'h05,8'h00},
    {4'd5, 1'b1,1'b1,8'h00,8'h05}, // R5 LDN readback
    {4'd9, 1'b0,1'b0,8'h30,8'h00},
    {4'd9, 1'b1,1'b1,8'h00,8'h00},
    {4'd9, 1'b0,1'b1,8'hFF,8'h00},
    {4'd9, 1'b1,1'b1,8'h00,8'h01}, // R9 only bit 0
    {4'd5, 1'b0,1'b0,8'h07,8'h00},
    {4'd5, 1'b0,1'b1,8'h06,8'h00},
    {4'd5, 1'b0,1'b0,8'h30,8'h00},
    {4'd5, 1'b1,1'b1,8'h00,8'h00}, // R5 other bank
    {4'd5, 1'b0,1'b0,8'h07,8'h00},
    {4'd5, 1'b0,1'b1,8'h05,8'h00},
    {4'd5, 1'b0,1'b0,8'h30,8'h00},
    {4'd5, 1'b1,1'b1,8'h00,8'h01},
    {4'd10,1'b0,1'b0,8'h60,8'h00},
    {4'd10,1'b1,1'b1,8'h00,8'h00}, // R10 claimed
    {4'd10,1'b0,1'b1,8'hA5,8'h00},
    {4'd10,1'b1,1'b1,8'h00,8'hA5},
    {4'd10,1'b0,1'b0,8'h61,8'h00},
    {4'd10,1'b1,1'b1,8'h00,8'hFF}, // R10 unclaimed
    {4'd10,1'b0,1'b0,8'h07,8'h00},
    {4'd10,1'b0,1'b1,8'h40,8'h00},
    {4'd10,1'b0,1'b0,8'h30,8'h00},
    {4'd10,1'b1,1'b1,8'h00,8'hFF}, // R10 LDN out of range
    {4'd10,1'b0,1'b1,8'h01,8'h00},
    {4'd10,1'b1,1'b1,8'h00,8'hFF},
    {4'd6, 1'b0,1'b0,8'h20,8'h00},
    {4'd6, 1'b1,1'b1,8'h00,8'hFE}, // R6 global with any LDN
    {4'd4, 1'b1,1'b0,8'h00,8'h20}, // R4 index readback
    {4'd3, 1'b0,1'b0,8'hAA,8'h00}, // R3 close
    {4'd3, 1'b1,1'b1,8'h00,8'hFF},
    {4'd3, 1'b1,1'b0,8'h00,8'hFF},
    {4'd1, 1'b0,1'b0,8'h07,8'h00},
    {4'd2, 1'b0,1'b0,8'h55,8'h00},
    {4'd3, 1'b1,1'b0,8'h00,8'h20}, // R3 index kept over close
    {4'd3, 1'b0,1'b0,8'hAA,8'h00}
  };

  initial begin
    #(CLK_PERIOD * 50000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 cfg_mode", {31'b0, cfg_mode}, 32'd0);
    check("R11 rvalid", {31'b0, io_rvalid}, 32'd0);
    check("R8 serirq reset", {31'b0, serirq_en}, 32'd1);
    check("R9 active reset", dev_active, 32'd0);
    check("R11 ldn", {24'b0, dev_ldn}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][21:18], i);
      if (VEC[i][17]) rd(16'h002E + 16'(VEC[i][16]), tag, VEC[i][7:0]);
      else            wr(16'h002E + 16'(VEC[i][16]), VEC[i][15:8]);
    end

    check("R9 dev_active pin", dev_active, 32'h0000_0020);
    check("R8 serirq pin", {31'b0, serirq_en}, 32'd1);
    check("R3 closed", {31'b0, cfg_mode}, 32'd0);

    // R2 wrong key keeps locked
    wr(16'h002E, 8'h56);
    check("R2 wrong key", {31'b0, cfg_mode}, 32'd0);
    // R12 no rvalid for other address
    @(negedge clk); io_addr = 16'h0080; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0;
    check("R12 no rvalid off-window", {31'b0, io_rvalid}, 32'd0);

    // relocated base: old address no longer opens
    port_base = 16'h004E;
    wr(16'h002E, 8'h55);
    check("R2 old base", {31'b0, cfg_mode}, 32'd0);
    wr(16'h004E, 8'h55);
    check("R2 new base", {31'b0, cfg_mode}, 32'd1);
    wr(16'h004E, 8'h07); wr(16'h004F, 8'h09);
    check("R5 ldn pin", {24'b0, dev_ldn}, 32'h09);

    // R11 reset while open
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R11 closed", {31'b0, cfg_mode}, 32'd0);
    check("R11 activate", dev_active, 32'd0);
    wr(16'h004E, 8'h55);
    rd(16'h004E, "R11 index", 8'h00);
    wr(16'h004E, 8'h07);
    rd(16'h004F, "R11 ldn read", 8'h00);
    wr(16'h004E, 8'hAA);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule